// File: doc/BRIEF.md
# Read-Only Message Readout Slave for a Two-Wire Bus

This block lets a bus master read a short decoded message over a two-wire serial bus (SCL/SDA, open-drain). The acquisition logic beside it hands over a complete seven-byte message with a one-cycle load strobe. The block stores the message in its bank and drives an active-low data-ready flag (`dav_n`) low. A master then addresses the block for reading and clocks the bytes out one after another. The master acknowledges each byte it wants the block to follow with another one.

The block never accepts writes. Once a readout finishes, or the master abandons it, the bank is refilled with 0xFF and `dav_n` returns high. Any later reads get 0xFF until a fresh message is loaded. A `bus_busy` output is high from START to STOP. Loads that arrive while it is high are dropped, so the acquisition side holds new messages back until the bus is quiet.

The controller has six states:
- IDLE: bus quiet.
- ADDR: shifting in the address byte.
- ADDR_ACK: pulling SDA low for the address acknowledge.
- TX: presenting data bits.
- RX_ACK: SDA released while the master's acknowledge is sampled.
- WAIT_STOP: SDA released until the next START or STOP.

The transitions are:
- START moves the controller from any state to ADDR.
- STOP moves it from any state to IDLE.
- ADDR→ADDR_ACK on the SCL fall after eight bits when the address and read bit match. ADDR→WAIT_STOP on that fall otherwise.
- ADDR_ACK→TX on the next SCL fall.
- TX→RX_ACK on the SCL fall that ends the eighth bit.
- RX_ACK→TX on the SCL fall when the master acknowledged. RX_ACK→WAIT_STOP on that fall when it did not.

Top module: `pdc_i2c_reader`

## Requirements
- R1: After reset `dav_n` is 1, `bus_busy` is 0, `sda_oe` is 0 and every bank byte reads 0xFF.
- R2: The block acknowledges the address byte 0x21 when `addr_sel` is 1 and 0x23 when `addr_sel` is 0. It acknowledges no other address byte and leaves `dav_n` unchanged when it rejects one.
- R3: An address byte with bit 0 (R/W) equal to 0 is not acknowledged. SDA stays released for the rest of that transaction and the stored message is untouched.
- R4: Data bytes go out byte 0 first (`load_data[7:0]`), each most significant bit first. `sda_oe` changes only while SCL is low.
- R5: A byte is followed by another only when the master acknowledged it (SDA low in the ninth clock). After a not-acknowledge SDA stays released until START or STOP.
- R6: The seventh byte always carries 1111 in its low four bits, whatever was loaded there. Its high four bits come from `load_data[55:52]`.
- R7: Once the seventh byte's acknowledge bit has been clocked, the bank reads 0xFF and `dav_n` is 1. Any further acknowledged bytes are 0xFF.
- R8: A STOP after at least one data byte has been sent in the transaction clears the bank to 0xFF and sets `dav_n` to 1.
- R9: Addressing the block again before a new load returns 0xFF bytes.
- R10: `bus_busy` rises on a START and falls on a STOP.
- R11: A load while `bus_busy` is 0 stores the message and drives `dav_n` low on the next cycle. A load while `bus_busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| addr_sel | input | 1 | Address select: 1 gives byte 0x21, 0 gives 0x23 |
| load | input | 1 | One-cycle strobe: a new message is on `load_data` |
| load_data | input | 56 | Message, byte k at bits [8k+7:8k] |
| dav_n | output | 1 | Low while an unread message is held |
| bus_busy | output | 1 | High from START to STOP |

## Verification
The bench uses the default parameters:
- a seven-byte message;
- a two-stage input synchroniser;
- the two default address bytes.

With these defaults the byte index reaches its saturated value inside one read, so a single transaction covers the forced low nibble of the last byte, the clear after the seventh acknowledge and the trailing 0xFF bytes. A bus quarter-period of twenty system clocks keeps the synchroniser delay well inside each SCL phase. Under that timing, START, STOP and both SCL edges are each seen exactly once.

// File: rtl/pdc_i2c_pkg.sv
package pdc_i2c_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_TX,
        ST_RX_ACK,
        ST_WAIT_STOP
    } rd_state_t;

    localparam logic [7:0] FILL_BYTE = 8'hFF;

endpackage

// File: rtl/pdc_i2c_cond.sv
// Synchronises SCL/SDA and flags SCL edges and START/STOP conditions.
module pdc_i2c_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    logic [SYNC_STAGES-1:0] scl_sr;
    logic [SYNC_STAGES-1:0] sda_sr;
    logic scl_d, sda_d, scl_now, sda_now;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                scl_sr[g] <= 1'b1;
                sda_sr[g] <= 1'b1;
            end else if (g == 0) begin
                scl_sr[g] <= scl_in;
                sda_sr[g] <= sda_in;
            end else begin
                scl_sr[g] <= scl_sr[(g == 0) ? 0 : g-1];
                sda_sr[g] <= sda_sr[(g == 0) ? 0 : g-1];
            end
        end
    end

    assign scl_now = scl_sr[SYNC_STAGES-1];
    assign sda_now = sda_sr[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_now;
            sda_d <= sda_now;
        end
    end

    assign sda_lvl  = sda_now;
    assign scl_rise = scl_now & ~scl_d;
    assign scl_fall = ~scl_now & scl_d;
    assign start_p  = scl_now & scl_d & sda_d & ~sda_now;
    assign stop_p   = scl_now & scl_d & ~sda_d & sda_now;
endmodule

// File: rtl/pdc_msg_bank.sv
// Output register bank: loads a message, clears to fill bytes, reads by index.
module pdc_msg_bank
    import pdc_i2c_pkg::*;
#(
    parameter int MSG_BYTES = 7,
    parameter int IDX_W     = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic [MSG_BYTES*8-1:0] load_data,
    input  logic                   clear,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic [7:0]             rd_byte,
    output logic                   dav_n
);
    logic [7:0] mem [MSG_BYTES];

    for (genvar g = 0; g < MSG_BYTES; g++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[g] <= FILL_BYTE;
            end else if (clear) begin
                mem[g] <= FILL_BYTE;
            end else if (load) begin
                if (g == MSG_BYTES-1) begin
                    mem[g] <= {load_data[8*g+7 -: 4], 4'hF};
                end else begin
                    mem[g] <= load_data[8*g +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dav_n <= 1'b1;
        end else if (clear) begin
            dav_n <= 1'b1;
        end else if (load) begin
            dav_n <= 1'b0;
        end
    end

    always_comb begin
        rd_byte = FILL_BYTE;
        for (int k = 0; k < MSG_BYTES; k++) begin
            if (rd_idx == IDX_W'(k)) rd_byte = mem[k];
        end
    end
endmodule

// File: rtl/pdc_i2c_reader.sv
// Read-only two-wire slave streaming a stored message.
module pdc_i2c_reader
    import pdc_i2c_pkg::*;
#(
    parameter int         MSG_BYTES   = 7,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] ADDR_HI     = 7'h10,
    parameter logic [6:0] ADDR_LO     = 7'h11
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_in,
    input  logic                   sda_in,
    output logic                   sda_oe,
    input  logic                   addr_sel,
    input  logic                   load,
    input  logic [MSG_BYTES*8-1:0] load_data,
    output logic                   dav_n,
    output logic                   bus_busy
);
    localparam int             IDX_W    = $clog2(MSG_BYTES + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MSG_BYTES - 1);
    localparam logic [IDX_W-1:0] END_IDX  = IDX_W'(MSG_BYTES);

    rd_state_t   state, state_nx;
    logic        sda_lvl, scl_rise, scl_fall, start_p, stop_p;
    logic [3:0]  bit_cnt;
    logic [IDX_W-1:0] idx;
    logic [7:0]  rxsr, txsr, rd_byte;
    logic        acked, data_sent, addr_hit, bank_clear;

    pdc_i2c_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_p(start_p), .stop_p(stop_p)
    );

    assign bank_clear = (state == ST_RX_ACK && scl_rise && idx == LAST_IDX)
                      || (stop_p && data_sent);

    pdc_msg_bank #(.MSG_BYTES(MSG_BYTES), .IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .load(load & ~bus_busy), .load_data(load_data),
        .clear(bank_clear), .rd_idx(idx), .rd_byte(rd_byte), .dav_n(dav_n)
    );

    assign addr_hit = rxsr[0] && (rxsr[7:1] == (addr_sel ? ADDR_HI : ADDR_LO));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      state_nx = ST_IDLE;
            ST_ADDR:      if (scl_fall && bit_cnt == 4'd8)
                              state_nx = addr_hit ? ST_ADDR_ACK : ST_WAIT_STOP;
            ST_ADDR_ACK:  if (scl_fall) state_nx = ST_TX;
            ST_TX:        if (scl_fall && bit_cnt == 4'd7) state_nx = ST_RX_ACK;
            ST_RX_ACK:    if (scl_fall) state_nx = acked ? ST_TX : ST_WAIT_STOP;
            ST_WAIT_STOP: state_nx = ST_WAIT_STOP;
            default:      state_nx = ST_IDLE;
        endcase
        if (start_p)     state_nx = ST_ADDR;
        else if (stop_p) state_nx = ST_IDLE;
    end

    // Outputs: SDA drive follows the state and the transmit register
    always_comb begin
        unique case (state)
            ST_ADDR_ACK: sda_oe = 1'b1;
            ST_TX:       sda_oe = ~txsr[7];
            default:     sda_oe = 1'b0;
        endcase
    end

    // Datapath: counters, shift registers, flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            idx       <= '0;
            rxsr      <= '0;
            txsr      <= 8'hFF;
            acked     <= 1'b0;
            data_sent <= 1'b0;
            bus_busy  <= 1'b0;
        end else begin
            if (start_p)     bus_busy <= 1'b1;
            else if (stop_p) bus_busy <= 1'b0;

            if (stop_p) data_sent <= 1'b0;

            if (start_p) begin
                bit_cnt <= '0;
                idx     <= '0;
            end else begin
                unique case (state)
                    ST_ADDR: if (scl_rise) begin
                        rxsr    <= {rxsr[6:0], sda_lvl};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                    ST_ADDR_ACK: if (scl_fall) begin
                        txsr      <= rd_byte;
                        bit_cnt   <= '0;
                        data_sent <= 1'b1;
                    end
                    ST_TX: if (scl_fall && bit_cnt != 4'd7) begin
                        txsr    <= {txsr[6:0], 1'b1};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                    ST_RX_ACK: begin
                        if (scl_rise) begin
                            acked <= ~sda_lvl;
                            if (idx != END_IDX) idx <= idx + 1'b1;
                        end
                        if (scl_fall && acked) begin
                            txsr    <= rd_byte;
                            bit_cnt <= '0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/pdc_i2c_reader_chk.sv
module pdc_i2c_reader_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_in,
    input logic load,
    input logic sda_oe,
    input logic dav_n,
    input logic bus_busy
);
    // R4: drive changes only while SCL is low
    a_r4_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_in);

    // R3: SDA is never pulled outside a transaction
    a_r3_drive_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> bus_busy);

    // R11: a new message is flagged only after an accepted load
    a_r11_dav_fall_from_load: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dav_n) |-> ($past(load) && !$past(bus_busy)));

    // R7 / R8: data-ready is released only by bus activity
    a_r8_dav_rise_in_txn: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dav_n) |-> $past(bus_busy));

    // R10: a transaction opens with SCL high (START)
    a_r10_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_busy) |-> scl_in);
endmodule

bind pdc_i2c_reader pdc_i2c_reader_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .load(load),
    .sda_oe(sda_oe), .dav_n(dav_n), .bus_busy(bus_busy)
);

// File: tb/sim_pdc_i2c_reader.sv
module sim_pdc_i2c_reader;
    localparam int Q = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        addr_sel = 1'b1;
    logic        load = 1'b0;
    logic [55:0] load_data = '0;
    logic        sda_oe, dav_n, bus_busy, sda_line;
    int          checks = 0;
    int          fails = 0;

    always #5 clk = ~clk;
    assign sda_line = m_sda & ~sda_oe;

    pdc_i2c_reader u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
        .sda_oe(sda_oe), .addr_sel(addr_sel), .load(load), .load_data(load_data),
        .dav_n(dav_n), .bus_busy(bus_busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq(); repeat (Q) @(negedge clk); endtask

    task automatic bus_start();
        m_sda = 1'b1; m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq();
    endtask

    task automatic put_bit(input logic b);
        m_sda = b; wq();
        m_scl = 1'b1; wq(); wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        b = sda_line; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic send_addr(input logic [7:0] a, output logic hit);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(a[i]);
        get_bit(b);
        hit = ~b;
    endtask

    task automatic read_byte(input logic ack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(~ack);
    endtask

    task automatic do_load(input logic [55:0] v);
        load_data = v; load = 1'b1;
        @(negedge clk); load = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [7:0] exp_byte(input logic [55:0] v, input int k);
        if (k == 6) return {v[55:52], 4'hF};
        return v[8*k +: 8];
    endfunction

    localparam logic [55:0] MSG_A = 56'h3C_96_01_E7_5A_C3_81;
    localparam logic [55:0] MSG_B = 56'h50_12_34_56_78_9A_4D;
    localparam logic [55:0] MSG_C = 56'h2B_77_66_55_44_33_B1;

    task automatic t_reset();
        chk(dav_n == 1'b1, "R1 dav_n after reset", dav_n, 1);
        chk(bus_busy == 1'b0, "R1 busy after reset", bus_busy, 0);
        chk(sda_oe == 1'b0, "R1 sda released after reset", sda_oe, 0);
    endtask

    task automatic t_empty_read();
        logic hit; logic [7:0] d;
        bus_start();
        send_addr(8'h21, hit);
        chk(hit, "R1 addr acked", hit, 1);
        read_byte(1'b0, d);
        chk(d == 8'hFF, "R1 bank fill after reset", d, 8'hFF);
        bus_stop();
    endtask

    task automatic t_full_read();
        logic hit; logic [7:0] d;
        do_load(MSG_A);
        chk(dav_n == 1'b0, "R11 dav_n low after load", dav_n, 0);
        bus_start();
        chk(bus_busy == 1'b1, "R10 busy after START", bus_busy, 1);
        send_addr(8'h21, hit);
        chk(hit, "R2 addr 0x21 acked with sel high", hit, 1);
        for (int k = 0; k < 7; k++) begin
            read_byte(1'b1, d);
            if (k == 6) chk(d == exp_byte(MSG_A, k), "R6 last byte nibble", d, exp_byte(MSG_A, k));
            else        chk(d == exp_byte(MSG_A, k), "R4 byte order MSB first", d, exp_byte(MSG_A, k));
        end
        chk(dav_n == 1'b1, "R7 dav_n high after seventh byte", dav_n, 1);
        read_byte(1'b1, d);
        chk(d == 8'hFF, "R7 extra byte is FF", d, 8'hFF);
        read_byte(1'b0, d);
        chk(d == 8'hFF, "R7 second extra byte is FF", d, 8'hFF);
        bus_stop();
        chk(bus_busy == 1'b0, "R10 busy cleared by STOP", bus_busy, 0);
    endtask

    task automatic t_reread();
        logic hit; logic [7:0] d;
        bus_start();
        send_addr(8'h21, hit);
        chk(hit, "R9 re-address acked", hit, 1);
        read_byte(1'b1, d);
        chk(d == 8'hFF, "R9 re-read byte 0 is FF", d, 8'hFF);
        read_byte(1'b0, d);
        chk(d == 8'hFF, "R9 re-read byte 1 is FF", d, 8'hFF);
        bus_stop();
    endtask

    task automatic t_sel_low_abort();
        logic hit, b; logic [7:0] d;
        addr_sel = 1'b0;
        do_load(MSG_B);
        bus_start();
        send_addr(8'h21, hit);
        chk(!hit, "R2 0x21 rejected with sel low", hit, 0);
        bus_stop();
        chk(dav_n == 1'b0, "R2 rejected address keeps dav_n", dav_n, 0);
        bus_start();
        send_addr(8'h23, hit);
        chk(hit, "R2 addr 0x23 acked with sel low", hit, 1);
        read_byte(1'b0, d);
        chk(d == exp_byte(MSG_B, 0), "R4 byte 0 with sel low", d, exp_byte(MSG_B, 0));
        get_bit(b);
        chk(b == 1'b1, "R5 SDA released after NACK bit 1", b, 1);
        get_bit(b);
        chk(b == 1'b1, "R5 SDA released after NACK bit 2", b, 1);
        chk(dav_n == 1'b0, "R8 dav_n still low before STOP", dav_n, 0);
        bus_stop();
        chk(dav_n == 1'b1, "R8 abort sets dav_n", dav_n, 1);
        bus_start();
        send_addr(8'h23, hit);
        read_byte(1'b0, d);
        chk(d == 8'hFF, "R8 bank cleared after abort", d, 8'hFF);
        bus_stop();
        addr_sel = 1'b1;
    endtask

    task automatic t_write_rejected();
        logic hit, b; logic [7:0] d;
        do_load(MSG_C);
        bus_start();
        send_addr(8'h20, hit);
        chk(!hit, "R3 write address not acked", hit, 0);
        get_bit(b);
        chk(b == 1'b1, "R3 SDA released after write address", b, 1);
        bus_stop();
        chk(dav_n == 1'b0, "R3 write attempt keeps dav_n", dav_n, 0);
        bus_start();
        send_addr(8'h21, hit);
        read_byte(1'b1, d);
        chk(d == exp_byte(MSG_C, 0), "R3 message intact after write attempt", d, exp_byte(MSG_C, 0));
        do_load(MSG_A);
        read_byte(1'b1, d);
        chk(d == exp_byte(MSG_C, 1), "R11 load during busy ignored", d, exp_byte(MSG_C, 1));
        read_byte(1'b0, d);
        chk(d == exp_byte(MSG_C, 2), "R11 byte 2 after ignored load", d, exp_byte(MSG_C, 2));
        bus_stop();
        chk(dav_n == 1'b1, "R11 ignored load left no message", dav_n, 1);
        do_load(MSG_B);
        chk(dav_n == 1'b0, "R11 idle load accepted", dav_n, 0);
        bus_start();
        send_addr(8'h21, hit);
        read_byte(1'b0, d);
        chk(d == exp_byte(MSG_B, 0), "R11 new message byte 0", d, exp_byte(MSG_B, 0));
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_empty_read();
        t_full_read();
        t_reread();
        t_sel_low_abort();
        t_write_rejected();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule